// File: doc/BRIEF.md
# Processor Operating State Controller

This block keeps track of the top-level operating state of a CPU core and of its privilege level. Each cycle it samples a set of single-cycle event pulses: two depths of reset, an exception/interrupt/trap event (which also serves as the wake-up interrupt), a return-from-exception event, a standby request with a mode select, a forced debug entry and a break event. A level input says whether a debugger is attached. From these it derives the next state, the user-mode bit, the low-power mode, a core clock enable, a memory-protection enable and a mask of the reset domains being held in reset.

There are five states. RESET is held while any reset pulse is present. NORMAL is ordinary execution, with a privilege/user split. LOWPWR is standby in one of three modes. DBG_USER is execution under a debugger, with the same privilege/user split. DBG_BREAK is the halted debug sub-state, which runs with privilege and with memory protection off. The transitions are: reset entry (any state to RESET), reset exit (RESET to NORMAL, or to DBG_USER when the debug latch is set), standby entry (NORMAL to LOWPWR), wake (LOWPWR to NORMAL), forced debug entry (NORMAL to DBG_USER), break (DBG_USER to DBG_BREAK) and debug return (DBG_BREAK to DBG_USER). Any other combination of events leaves the state where it is. A sticky debug latch is set on forced entry and is cleared only by an initialize-level reset. Because of this latch, a reset-level reset taken under the debugger returns the core to DBG_USER.

Top module: `proc_opstate_ctrl`

## Requirements
- R1: When `init_rst` or `lvl_rst` is sampled high, `op_state` is RESET (encoding 0) in the next cycle, and it stays RESET while either pulse is held. While in RESET, `rst_dom_en` reads 3'b111 after an initialize-level reset or after power-on (`rst_n` low), and reads 3'b001 after a reset-level reset alone. If both pulses arrive together, the value is 3'b111. Outside RESET, `rst_dom_en` is 0.
- R2: The first cycle in RESET with no reset pulse moves the core to NORMAL (encoding 1), or to DBG_USER (encoding 3) when the debug latch is set. In either case `user_mode` is 0.
- R3: In NORMAL and in DBG_USER, `reti_evt` sets `user_mode` to 1 and `irq_evt` clears it to 0.
- R4: In NORMAL, `stby_req` moves the core to LOWPWR (encoding 2), and `lp_mode` shows the requested mode (00 sleep, 01 stop, 10 clock). A request with mode 11 is ignored. Outside LOWPWR, `lp_mode` is 00.
- R5: In LOWPWR, only `irq_evt` or a reset ends the state. `irq_evt` returns the core to NORMAL with `user_mode` 0. `reti_evt`, `brk_evt`, `stby_req` and `force_dbg` have no effect there.
- R6: `core_clk_en` is 0 in LOWPWR with the stop or clock mode, and 1 in every other case, including sleep.
- R7: In NORMAL, `force_dbg` together with `dbg_present` moves the core to DBG_USER, keeps `user_mode` and sets the debug latch. `force_dbg` without `dbg_present`, and `brk_evt`, are ignored in NORMAL.
- R8: In DBG_USER, `brk_evt` moves the core to DBG_BREAK (encoding 4). In DBG_BREAK, `user_mode` and `mprot_en` are 0, and `irq_evt` has no effect. `reti_evt` returns the core to DBG_USER with the user-mode value it had before the break. `mprot_en` is 1 in every state other than DBG_BREAK.
- R9: The core leaves DBG_USER and DBG_BREAK only through RESET. After a reset-level reset it comes back to DBG_USER. After an initialize-level reset it comes back to NORMAL.
- R10: When several events arrive in the same cycle, they are resolved in this order: reset, then forced debug entry, then break, then `irq_evt`, then `reti_evt`, then standby. Only the winning event has an effect. An event that does not apply in the current state does not block a lower-ranked event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| init_rst | input | 1 | Initialize-level reset pulse |
| lvl_rst | input | 1 | Reset-level reset pulse |
| irq_evt | input | 1 | Exception/interrupt/trap event, also used as wake-up |
| reti_evt | input | 1 | Return-from-exception executed |
| stby_req | input | 1 | Standby request |
| stby_mode | input | 2 | Requested low-power mode |
| dbg_present | input | 1 | Debugger attached |
| force_dbg | input | 1 | Forced debug entry |
| brk_evt | input | 1 | Break event |
| op_state | output | 3 | Current operating state |
| user_mode | output | 1 | 1 = user mode, 0 = privilege |
| lp_mode | output | 2 | Active low-power mode |
| core_clk_en | output | 1 | Core clock enable |
| mprot_en | output | 1 | Memory protection enable |
| rst_dom_en | output | 3 | Reset domains held: bit0 core, bit1 clock/reset control, bit2 debug control |

## Verification
The bench targets these corner cases:
- A reset-level reset taken while debugging. A design that clears the debug latch on it would come back to NORMAL instead of DBG_USER.
- A return from DBG_BREAK. A design that forces privilege into the saved mode would lose the user bit.
- Stacked events, such as break with interrupt, or forced entry with interrupt. A design with the wrong ranking would change `user_mode` or pick the wrong state.
- Standby with the reserved mode 11, and events that the low-power state must ignore. A careless decoder would enter LOWPWR, or wake on `reti_evt`.

Random stimulus then mixes all of these with occasional resets.

// File: rtl/opst_pkg.sv
package opst_pkg;
    typedef enum logic [2:0] {
        OS_RESET     = 3'd0,
        OS_NORMAL    = 3'd1,
        OS_LOWPWR    = 3'd2,
        OS_DBG_USER  = 3'd3,
        OS_DBG_BREAK = 3'd4
    } opst_e;

    localparam int STATE_W = 3;
    localparam int LP_W    = 2;

    localparam logic [LP_W-1:0] LP_SLEEP    = 2'b00;
    localparam logic [LP_W-1:0] LP_STOP     = 2'b01;
    localparam logic [LP_W-1:0] LP_CLOCK    = 2'b10;
    localparam logic [LP_W-1:0] LP_RESERVED = 2'b11;

    typedef struct packed {
        logic init_rst;
        logic lvl_rst;
        logic force_dbg;
        logic brk;
        logic irq;
        logic reti;
        logic stby;
    } opst_evt_t;
endpackage

// File: rtl/opst_next.sv
module opst_next
    import opst_pkg::*;
#(
    parameter int DOM_W = 3
) (
    input  opst_e            cur_state,
    input  logic             cur_um,
    input  logic             cur_latch,
    input  logic [LP_W-1:0]  cur_lp,
    input  logic [DOM_W-1:0] cur_mask,
    input  opst_evt_t        evt,
    input  logic [LP_W-1:0]  req_mode,
    input  logic             dbg_present,
    output opst_e            nxt_state,
    output logic             nxt_um,
    output logic             nxt_latch,
    output logic [LP_W-1:0]  nxt_lp,
    output logic [DOM_W-1:0] nxt_mask
);
    localparam logic [DOM_W-1:0] MASK_ALL = {DOM_W{1'b1}};
    localparam logic [DOM_W-1:0] MASK_LVL = {{(DOM_W-1){1'b0}}, 1'b1};

    always_comb begin
        nxt_state = cur_state;
        nxt_um    = cur_um;
        nxt_latch = cur_latch;
        nxt_lp    = cur_lp;
        nxt_mask  = cur_mask;
        if (evt.init_rst || evt.lvl_rst) begin
            nxt_state = OS_RESET;
            nxt_um    = 1'b0;
            nxt_mask  = evt.init_rst ? MASK_ALL : MASK_LVL;
            if (evt.init_rst) nxt_latch = 1'b0;
        end else begin
            unique case (cur_state)
                OS_RESET: begin
                    nxt_state = cur_latch ? OS_DBG_USER : OS_NORMAL;
                    nxt_um    = 1'b0;
                end
                OS_NORMAL: begin
                    if (evt.force_dbg && dbg_present) begin
                        nxt_state = OS_DBG_USER;
                        nxt_latch = 1'b1;
                    end else if (evt.irq) begin
                        nxt_um = 1'b0;
                    end else if (evt.reti) begin
                        nxt_um = 1'b1;
                    end else if (evt.stby && req_mode != LP_RESERVED) begin
                        nxt_state = OS_LOWPWR;
                        nxt_lp    = req_mode;
                    end
                end
                OS_LOWPWR: begin
                    if (evt.irq) begin
                        nxt_state = OS_NORMAL;
                        nxt_um    = 1'b0;
                    end
                end
                OS_DBG_USER: begin
                    if (evt.brk) begin
                        nxt_state = OS_DBG_BREAK;
                    end else if (evt.irq) begin
                        nxt_um = 1'b0;
                    end else if (evt.reti) begin
                        nxt_um = 1'b1;
                    end
                end
                OS_DBG_BREAK: begin
                    if (evt.reti) nxt_state = OS_DBG_USER;
                end
                default: nxt_state = OS_RESET;
            endcase
        end
    end
endmodule

// File: rtl/opst_outputs.sv
module opst_outputs
    import opst_pkg::*;
#(
    parameter int DOM_W = 3
) (
    input  opst_e            state,
    input  logic             um,
    input  logic [LP_W-1:0]  lp,
    input  logic [DOM_W-1:0] mask,
    output logic             user_mode,
    output logic [LP_W-1:0]  lp_mode,
    output logic             core_clk_en,
    output logic             mprot_en,
    output logic [DOM_W-1:0] rst_dom_en
);
    always_comb begin
        user_mode   = 1'b0;
        lp_mode     = LP_SLEEP;
        core_clk_en = 1'b1;
        mprot_en    = 1'b1;
        rst_dom_en  = '0;
        unique case (state)
            OS_RESET:     rst_dom_en = mask;
            OS_NORMAL:    user_mode = um;
            OS_LOWPWR: begin
                lp_mode     = lp;
                core_clk_en = (lp == LP_SLEEP);
            end
            OS_DBG_USER:  user_mode = um;
            OS_DBG_BREAK: mprot_en = 1'b0;
            default:      rst_dom_en = mask;
        endcase
    end
endmodule

// File: rtl/proc_opstate_ctrl.sv
module proc_opstate_ctrl
    import opst_pkg::*;
#(
    parameter int DOM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_rst,
    input  logic             lvl_rst,
    input  logic             irq_evt,
    input  logic             reti_evt,
    input  logic             stby_req,
    input  logic [1:0]       stby_mode,
    input  logic             dbg_present,
    input  logic             force_dbg,
    input  logic             brk_evt,
    output logic [2:0]       op_state,
    output logic             user_mode,
    output logic [1:0]       lp_mode,
    output logic             core_clk_en,
    output logic             mprot_en,
    output logic [DOM_W-1:0] rst_dom_en
);
    opst_e            state_q, state_d;
    logic             um_q, um_d, latch_q, latch_d;
    logic [LP_W-1:0]  lp_q, lp_d;
    logic [DOM_W-1:0] mask_q, mask_d;
    opst_evt_t        evt;

    assign evt = '{init_rst: init_rst, lvl_rst: lvl_rst, force_dbg: force_dbg,
                   brk: brk_evt, irq: irq_evt, reti: reti_evt, stby: stby_req};

    opst_next #(.DOM_W(DOM_W)) u_next (
        .cur_state(state_q), .cur_um(um_q), .cur_latch(latch_q), .cur_lp(lp_q),
        .cur_mask(mask_q), .evt(evt), .req_mode(stby_mode), .dbg_present(dbg_present),
        .nxt_state(state_d), .nxt_um(um_d), .nxt_latch(latch_d), .nxt_lp(lp_d),
        .nxt_mask(mask_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_RESET;
            um_q    <= 1'b0;
            latch_q <= 1'b0;
            lp_q    <= LP_SLEEP;
            mask_q  <= {DOM_W{1'b1}};
        end else begin
            state_q <= state_d;
            um_q    <= um_d;
            latch_q <= latch_d;
            lp_q    <= lp_d;
            mask_q  <= mask_d;
        end
    end

    opst_outputs #(.DOM_W(DOM_W)) u_out (
        .state(state_q), .um(um_q), .lp(lp_q), .mask(mask_q),
        .user_mode(user_mode), .lp_mode(lp_mode), .core_clk_en(core_clk_en),
        .mprot_en(mprot_en), .rst_dom_en(rst_dom_en)
    );

    assign op_state = state_q;

    p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (init_rst || lvl_rst) |=> (op_state == OS_RESET));

    p_reset_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OS_RESET && !init_rst && !lvl_rst) |=>
        ((op_state == OS_NORMAL || op_state == OS_DBG_USER) && !user_mode));

    p_stay_lowpwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OS_LOWPWR && !irq_evt && !init_rst && !lvl_rst) |=>
        (op_state == OS_LOWPWR && $stable(lp_mode)));

    p_clock_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OS_LOWPWR && lp_mode != LP_SLEEP) |-> !core_clk_en);

    p_break_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OS_DBG_BREAK) |-> (!user_mode && !mprot_en));

    p_dbg_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OS_DBG_USER || op_state == OS_DBG_BREAK) |=>
        (op_state == OS_DBG_USER || op_state == OS_DBG_BREAK || op_state == OS_RESET));
endmodule

// File: tb/proc_opstate_ctrl_test.sv
module proc_opstate_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_rst = 0, lvl_rst = 0, irq_evt = 0, reti_evt = 0, stby_req = 0;
    logic [1:0] stby_mode = 2'b00;
    logic dbg_present = 0, force_dbg = 0, brk_evt = 0;
    logic [2:0] op_state;
    logic user_mode, core_clk_en, mprot_en;
    logic [1:0] lp_mode;
    logic [2:0] rst_dom_en;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // reference model state
    int m_st = 0;
    bit m_um = 0, m_latch = 0;
    logic [1:0] m_lp = 2'b00;
    logic [2:0] m_mask = 3'b111;

    always #2 clk = ~clk;

    proc_opstate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .init_rst(init_rst), .lvl_rst(lvl_rst),
        .irq_evt(irq_evt), .reti_evt(reti_evt), .stby_req(stby_req),
        .stby_mode(stby_mode), .dbg_present(dbg_present), .force_dbg(force_dbg),
        .brk_evt(brk_evt), .op_state(op_state), .user_mode(user_mode),
        .lp_mode(lp_mode), .core_clk_en(core_clk_en), .mprot_en(mprot_en),
        .rst_dom_en(rst_dom_en)
    );

    function automatic bit exp_um();
        return m_um && (m_st == 1 || m_st == 3);
    endfunction
    function automatic logic [1:0] exp_lp();
        return (m_st == 2) ? m_lp : 2'b00;
    endfunction
    function automatic bit exp_clk();
        return !(m_st == 2 && m_lp != 2'b00);
    endfunction
    function automatic bit exp_mprot();
        return m_st != 4;
    endfunction
    function automatic logic [2:0] exp_mask();
        return (m_st == 0) ? m_mask : 3'b000;
    endfunction

    task automatic model_step();
        if (init_rst || lvl_rst) begin
            m_st = 0; m_um = 0;
            m_mask = init_rst ? 3'b111 : 3'b001;
            if (init_rst) m_latch = 0;
        end else begin
            case (m_st)
                0: begin m_st = m_latch ? 3 : 1; m_um = 0; end
                1: begin
                    if (force_dbg && dbg_present) begin m_st = 3; m_latch = 1; end
                    else if (irq_evt) m_um = 0;
                    else if (reti_evt) m_um = 1;
                    else if (stby_req && stby_mode != 2'b11) begin m_st = 2; m_lp = stby_mode; end
                end
                2: if (irq_evt) begin m_st = 1; m_um = 0; end
                3: begin
                    if (brk_evt) m_st = 4;
                    else if (irq_evt) m_um = 0;
                    else if (reti_evt) m_um = 1;
                end
                4: if (reti_evt) m_st = 3;
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "op_state", int'(op_state), m_st);
        chk(tag, "user_mode", int'(user_mode), int'(exp_um()));
        chk(tag, "lp_mode", int'(lp_mode), int'(exp_lp()));
        chk(tag, "core_clk_en", int'(core_clk_en), int'(exp_clk()));
        chk(tag, "mprot_en", int'(mprot_en), int'(exp_mprot()));
        chk(tag, "rst_dom_en", int'(rst_dom_en), int'(exp_mask()));
    endtask

    task automatic step(input bit i_init, input bit i_lvl, input bit i_irq, input bit i_reti,
                        input bit i_stby, input logic [1:0] i_mode, input bit i_pres,
                        input bit i_force, input bit i_brk, input string tag);
        @(negedge clk);
        init_rst = i_init; lvl_rst = i_lvl; irq_evt = i_irq; reti_evt = i_reti;
        stby_req = i_stby; stby_mode = i_mode; dbg_present = i_pres;
        force_dbg = i_force; brk_evt = i_brk;
        model_step();
        @(posedge clk);
        #1;
        cyc++;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 2'b00, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 power-on");
        @(negedge clk);
        rst_n = 1'b1;

        idle("R2 exit to NORMAL");
        step(0,0,0,1,0,2'b00,0,0,0, "R3 reti");
        step(0,0,1,0,0,2'b00,0,0,0, "R3 irq");
        step(0,0,0,1,0,2'b00,0,0,0, "R3 reti again");
        step(0,0,0,0,1,2'b11,0,0,0, "R4 reserved mode");
        step(0,0,0,0,1,2'b01,0,0,0, "R4 R6 stop");
        step(0,0,0,1,1,2'b10,1,1,1, "R5 ignored in LOWPWR");
        step(0,0,1,0,0,2'b00,0,0,0, "R5 wake");
        step(0,0,0,0,1,2'b00,0,0,0, "R6 sleep");
        step(0,0,1,0,0,2'b00,0,0,0, "R5 wake sleep");
        step(0,0,0,0,1,2'b10,0,0,0, "R6 clock mode");
        step(0,0,1,0,0,2'b00,0,0,0, "R5 wake clock");
        step(0,0,0,1,0,2'b00,0,0,0, "R3 user");
        step(0,0,0,0,0,2'b00,0,0,1, "R7 brk ignored");
        step(0,0,0,0,0,2'b00,0,1,0, "R7 force no debugger");
        step(0,0,1,0,0,2'b00,1,1,0, "R10 force beats irq");
        step(0,0,1,0,0,2'b00,0,0,1, "R10 brk beats irq");
        step(0,0,1,0,0,2'b00,0,0,0, "R8 irq ignored in break");
        step(0,0,0,1,0,2'b00,0,0,0, "R8 return restores user");
        step(0,0,1,1,0,2'b00,0,0,0, "R10 irq beats reti");
        step(0,0,0,0,1,2'b01,1,1,0, "R9 no exit by standby");
        step(0,1,0,0,0,2'b00,0,0,0, "R1 level mask");
        idle("R9 level reset back to DBG_USER");
        step(1,0,0,1,0,2'b00,0,0,0, "R1 init mask");
        step(1,0,0,0,0,2'b00,0,0,0, "R1 held");
        idle("R9 init reset back to NORMAL");
        step(1,1,0,0,0,2'b00,0,0,0, "R10 both resets");
        idle("R2 after both");

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 60) == 0, ($urandom % 50) == 0, ($urandom % 4) == 0,
                 ($urandom % 4) == 0, ($urandom % 5) == 0, 2'($urandom % 4),
                 ($urandom % 2) == 0, ($urandom % 15) == 0, ($urandom % 6) == 0,
                 "R10 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule